// File: doc/BRIEF.md
# SAR converter serial host controller

This block runs one conversion and one serial frame on a successive-approximation converter for each accepted start request. The converter has a convert/busy handshake and a four-wire serial port. The controller raises the convert strobe and waits out a programmable aperture interval. It then runs a frame of 16 SCK cycles, or 32 cycles when configuration readback is enabled. During the frame it shifts a fresh 16-bit configuration word out on DIN and captures the result, and optionally the readback word, from SDO.

The frame may start while the converter is still busy. In that case it returns the result of the previous conversion. Otherwise it waits for BUSY to drop and returns the result just produced. Each result leaves on a held valid/ready beat. The beat carries:
- a sequence index;
- a flag that marks the two start-up frames as not trustworthy;
- the configuration word that governed that conversion, taken from a small history of the words written.

BUSY is taken as synchronous to `clk`. SCK idles low. Both serial directions are MSB first.

Top module: `sar_host_ctrl`

## Requirements
- R1: A start request is accepted only when the controller is idle. An accepted request drives `cnv` high for exactly CNV_CYC (default 2) cycles, and each accepted request gives exactly one convert pulse.
- R2: SCK idles low. No SCK rising edge occurs fewer than `ap_dly` cycles after the cycle in which `cnv` rose, and SCK stays low while `cnv` is high.
- R3: A frame has exactly 16 SCK falling edges when `rb_en` is 0 and 32 when it is 1. SDO is sampled on each SCK rising edge, MSB first. The first 16 bits go to `out_res` and the next 16 to `out_rb`. `out_rb` is 0 when readback is off.
- R4: DIN carries `cfg_in`, as captured at the start, MSB first. It changes only with SCK falling edges. It sends bits only during the first 16 SCK cycles of a frame and is 0 for the rest of the frame.
- R5: When the aperture interval ends, the controller tests BUSY and the elapsed count from the `cnv` rise. If BUSY is high and the count is below `busy_cut`, the frame starts at once and `out_idx` is the previous conversion number (k-1, modulo 2^SEQW). If BUSY is high and the count is not below `busy_cut`, the controller waits for BUSY low. In that case, and whenever BUSY is already low, `out_idx` is the current conversion number k. Conversions are numbered from 0 after reset.
- R6: `out_cfg` equals the `cfg_in` word accepted with start number `out_idx`-2, or 0 when `out_idx` is below 2. This is the configuration that governed the returned result.
- R7: `cs_mode` selects the CS behaviour:
  - 2'b00 and 2'b11: independent, with `cs_n` low only during the frame.
  - 2'b01: `cs_n` follows `cnv`.
  - 2'b10: `cs_n` is held low.

  In every mode, `cs_n` is low whenever SCK is high.
- R8: `out_good` is 0 on the first two beats after reset and 1 on every later beat.
- R9: A start request made while the controller is not idle is ignored and produces no convert pulse. `out_ovr` is high for one cycle in the following cycle. A beat that has not yet been taken counts as not idle.
- R10: A beat stays valid with all of its fields unchanged until `out_ready` is high. The controller returns to idle only after the beat is taken and BUSY is low.
- R11: After reset, `cnv`, `sck`, `din` and `out_vld` are 0, and `cs_n` is 1 in independent mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Conversion-and-frame request |
| cfg_in | input | DW | Configuration word to send in this frame |
| rb_en | input | 1 | Enables the second 16-bit readback word |
| cs_mode | input | 2 | Chip-select mode (see R7) |
| sck_half | input | CW | SCK half period in clock cycles (0 acts as 1) |
| ap_dly | input | CW | Aperture interval in cycles from the `cnv` rise |
| busy_cut | input | CW | Elapsed-cycle limit for starting a frame while BUSY is high |
| cnv | output | 1 | Convert strobe |
| busy | input | 1 | Converter busy, synchronous |
| cs_n | output | 1 | Chip select, active low |
| sck | output | 1 | Serial clock |
| din | output | 1 | Serial data to the converter |
| sdo | input | 1 | Serial data from the converter |
| out_vld | output | 1 | Beat valid |
| out_ready | input | 1 | Beat accepted |
| out_res | output | DW | Conversion result |
| out_rb | output | DW | Readback configuration word |
| out_cfg | output | DW | Configuration that governed the result |
| out_good | output | 1 | Result is trustworthy (not a start-up frame) |
| out_idx | output | SEQW | Conversion number of the result |
| out_ovr | output | 1 | One-cycle pulse for a rejected start |

## Verification
The hardest case to reach from the ports is the one where the returned conversion number depends on how BUSY, the aperture count and the cutoff line up. To reach it, the sweep runs three timing set-ups:
- an aperture that ends inside BUSY with the cutoff not yet reached;
- an aperture that ends inside BUSY after the cutoff has passed;
- a cutoff of zero.

A behavioural converter in the bench stores the configuration it receives on DIN, applies it two conversions later, and returns it on readback. This lets the bench check the index, the result and the configuration tag from its own record of starts. Rejected starts are forced in two ways: mid-conversion, and while a finished beat is deliberately held with `out_ready` low.

// File: rtl/sar_host_ctrl.sv
module sar_host_ctrl #(
  parameter int DW = 16,
  parameter int CW = 12,
  parameter int SEQW = 8,
  parameter int CNV_CYC = 2,
  parameter logic [DW-1:0] CFG_RST = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [DW-1:0]   cfg_in,
  input  logic            rb_en,
  input  logic [1:0]      cs_mode,
  input  logic [CW-1:0]   sck_half,
  input  logic [CW-1:0]   ap_dly,
  input  logic [CW-1:0]   busy_cut,
  output logic            cnv,
  input  logic            busy,
  output logic            cs_n,
  output logic            sck,
  output logic            din,
  input  logic            sdo,
  output logic            out_vld,
  input  logic            out_ready,
  output logic [DW-1:0]   out_res,
  output logic [DW-1:0]   out_rb,
  output logic [DW-1:0]   out_cfg,
  output logic            out_good,
  output logic [SEQW-1:0] out_idx,
  output logic            out_ovr
);
  localparam int BW = $clog2(2*DW) + 1;
  localparam int IW = $clog2(DW);

  typedef enum logic [2:0] {S_IDLE, S_CNV, S_APER, S_WAITB, S_SHIFT, S_HOLD} st_t;
  st_t st;

  logic [CW-1:0]   tmr, hc;
  logic [BW-1:0]   bc;
  logic [2*DW-1:0] shreg;
  logic [DW-1:0]   cfg_q;
  logic            rb_q, dur_q, sck_q;
  logic [SEQW-1:0] kc;
  logic [1:0]      nfr;
  logic [DW-1:0]   hist [4];

  wire tick = ({1'b0, hc} + 1'b1) >= {1'b0, sck_half};
  wire [BW-1:0] nbits = rb_q ? BW'(2*DW) : BW'(DW);
  wire last = tick && sck_q && (bc == nbits - 1'b1);
  wire [SEQW-1:0] idx = dur_q ? kc - 1'b1 : kc;
  wire early = busy && (tmr < busy_cut);
  wire [IW-1:0] bi = IW'(DW-1) - bc[IW-1:0];

  assign cnv = (st == S_CNV);
  assign sck = sck_q;
  assign din = (st == S_SHIFT) && (bc < BW'(DW)) && cfg_q[bi];

  always_comb
    case (cs_mode)
      2'b01:   cs_n = cnv;
      2'b10:   cs_n = 1'b0;
      default: cs_n = (st != S_SHIFT);
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE;
      tmr <= '0; hc <= '0; bc <= '0; shreg <= '0; cfg_q <= '0;
      rb_q <= 1'b0; dur_q <= 1'b0; sck_q <= 1'b0; kc <= '0; nfr <= '0;
      for (int i = 0; i < 4; i++) hist[i] <= CFG_RST;
      out_vld <= 1'b0; out_res <= '0; out_rb <= '0; out_cfg <= '0;
      out_good <= 1'b0; out_idx <= '0; out_ovr <= 1'b0;
    end else begin
      out_ovr <= start && (st != S_IDLE);
      if (out_vld && out_ready) out_vld <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          cfg_q <= cfg_in;
          rb_q <= rb_en;
          tmr <= '0;
          hist[kc[1:0] + 2'd2] <= cfg_in;
          st <= S_CNV;
        end
        S_CNV: begin
          tmr <= tmr + 1'b1;
          if (tmr == CW'(CNV_CYC - 1)) st <= S_APER;
        end
        S_APER: if (tmr >= ap_dly) begin
          hc <= '0;
          bc <= '0;
          dur_q <= early;
          st <= (busy && !early) ? S_WAITB : S_SHIFT;
        end else tmr <= tmr + 1'b1;
        S_WAITB: if (!busy) st <= S_SHIFT;
        S_SHIFT: if (tick) begin
          hc <= '0;
          if (!sck_q) begin
            sck_q <= 1'b1;
            shreg <= {shreg[2*DW-2:0], sdo};
          end else begin
            sck_q <= 1'b0;
            bc <= bc + 1'b1;
            if (last) begin
              st <= S_HOLD;
              out_vld <= 1'b1;
              out_res <= rb_q ? shreg[2*DW-1:DW] : shreg[DW-1:0];
              out_rb <= rb_q ? shreg[DW-1:0] : '0;
              out_cfg <= hist[idx[1:0]];
              out_good <= (nfr == 2'd2);
              out_idx <= idx;
              if (nfr != 2'd2) nfr <= nfr + 1'b1;
            end
          end
        end else hc <= hc + 1'b1;
        S_HOLD: if (!busy && !out_vld) begin
          st <= S_IDLE;
          kc <= kc + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end

  a_r1_cnv_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cnv) |-> $past(st) == S_IDLE);
  a_r2_no_sck_in_cnv: assert property (@(posedge clk) disable iff (!rst_n)
    cnv |-> !sck);
  a_r3_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_IDLE |-> !sck && !din);
  a_r7_cs_on_sck: assert property (@(posedge clk) disable iff (!rst_n)
    sck |-> !cs_n);
  a_r9_reject: assert property (@(posedge clk) disable iff (!rst_n)
    start && st != S_IDLE |=> !$rose(cnv));
  a_r10_beat_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld && !out_ready |=> out_vld && $stable(out_res) && $stable(out_rb)
      && $stable(out_cfg) && $stable(out_idx) && $stable(out_good));
endmodule

// File: tb/sim_sar_host_ctrl.sv
module sim_sar_host_ctrl;
  localparam int CONV_T = 40;

  logic clk = 0, rst_n = 0, start = 0, rb_en = 0, busy = 0, out_ready = 0;
  logic [15:0] cfg_in = 0;
  logic [1:0] cs_mode = 0;
  logic [11:0] sck_half = 1, ap_dly = 3, busy_cut = 0;
  logic cnv, cs_n, sck, din, sdo, out_vld, out_good, out_ovr;
  logic [15:0] out_res, out_rb, out_cfg;
  logic [7:0] out_idx;

  sar_host_ctrl u0 (.clk, .rst_n, .start, .cfg_in, .rb_en, .cs_mode, .sck_half,
    .ap_dly, .busy_cut, .cnv, .busy, .cs_n, .sck, .din, .sdo, .out_vld,
    .out_ready, .out_res, .out_rb, .out_cfg, .out_good, .out_idx, .out_ovr);

  always #5 clk = ~clk;

  int nchk = 0, nerr = 0;
  bit done = 0;

  function automatic logic [15:0] resf(int j);
    return 16'hC3A5 ^ 16'(j * 731);
  endfunction
  function automatic logic [15:0] cfgv(int s);
    return 16'h5A3C ^ 16'(s * 4099);
  endfunction
  function automatic logic [15:0] expcfg(int j);
    return (j >= 2) ? cfgv(j - 2) : 16'h0;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // behavioural converter
  logic [15:0] dev_res = 16'hDEAD, dev_cfg = 16'h0, din_sr = 16'h0;
  logic [15:0] cfgconv [64];
  int dc = 0, bt = 0, cur = 0, nfall = 0, base = 0, bitcnt, din_hi = 0;
  logic cnv_d = 0;
  logic [31:0] lat = 0;
  wire [31:0] live = {dev_res, dev_cfg};
  always_comb bitcnt = nfall - base;
  assign sdo = (bitcnt == 0) ? live[31] : ((bitcnt < 32) ? lat[31 - bitcnt] : 1'b0);

  initial for (int i = 0; i < 64; i++) cfgconv[i] = 16'h0;

  always @(posedge clk) begin
    cnv_d <= cnv;
    if (cnv && !cnv_d) begin
      busy <= 1'b1;
      bt <= CONV_T;
      cur <= dc;
      cfgconv[(dc + 1) % 64] <= din_sr;
      dc <= dc + 1;
    end else if (bt > 0) begin
      bt <= bt - 1;
      if (bt == 1) begin
        busy <= 1'b0;
        dev_res <= resf(cur);
        dev_cfg <= cfgconv[cur % 64];
      end
    end
  end
  always @(posedge sck) begin
    if (bitcnt == 0) lat <= live;
    if (bitcnt < 16) din_sr <= {din_sr[14:0], din};
    else if (din) din_hi <= din_hi + 1;
  end
  always @(negedge sck) nfall <= nfall + 1;

  // port monitor
  int cyc = 0, t_cnv = 0, t_sck1 = -1, cnv_hi = 0, n_cnv = 0, cs_err = 0;
  logic m_cnv = 0, m_sck = 0;
  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cnv && !m_cnv) begin t_cnv = cyc; n_cnv = n_cnv + 1; end
    if (sck && !m_sck && t_sck1 < t_cnv) t_sck1 = cyc;
    if (cnv) cnv_hi = cnv_hi + 1;
    if (rst_n) begin
      if (sck && cs_n) cs_err = cs_err + 1;
      if (cs_mode == 2'b01 && cs_n != cnv) cs_err = cs_err + 1;
      if (cs_mode == 2'b10 && cs_n) cs_err = cs_err + 1;
      if ((cs_mode == 2'b00 || cs_mode == 2'b11) && cnv && !cs_n) cs_err = cs_err + 1;
    end
    m_cnv = cnv;
    m_sck = sck;
  end

  int s = 0;

  task automatic run(input int tm, input int mode, input bit rb, input int half);
    int c0, n0, e0, h0, ei, w;
    bit during;
    logic [15:0] hres;
    @(negedge clk);
    cs_mode = 2'(mode);
    rb_en = rb;
    sck_half = 12'(half);
    ap_dly = (tm == 2) ? 12'd30 : 12'd3;
    busy_cut = (tm == 1) ? 12'd0 : 12'd20;
    during = (tm == 0);
    repeat (2) @(negedge clk);
    base = nfall;
    c0 = cnv_hi; n0 = n_cnv; e0 = cs_err; h0 = din_hi;
    cfg_in = cfgv(s);
    start = 1;
    @(negedge clk);
    start = 0;
    if (s % 5 == 2) begin
      repeat (2) @(negedge clk);
      start = 1;
      @(negedge clk);
      start = 0;
      chk(out_ovr, "R9 start during conversion flags overrun", 32'(out_ovr), 1);
    end
    w = 0;
    while (!out_vld && w < 3000) begin @(negedge clk); w++; end
    chk(out_vld, "R1 beat arrives", 32'(out_vld), 1);
    ei = during ? s - 1 : s;
    chk(out_idx == 8'(ei), "R5 result index", 32'(out_idx), 32'(8'(ei)));
    chk(out_good == (s >= 2), "R8 good flag", 32'(out_good), 32'(s >= 2));
    if (s >= 2) chk(out_res == resf(ei), "R3 result word", 32'(out_res), 32'(resf(ei)));
    if (rb && s >= 2) chk(out_rb == expcfg(ei), "R3 readback word", 32'(out_rb), 32'(expcfg(ei)));
    if (!rb) chk(out_rb == 16'h0, "R3 readback zero when off", 32'(out_rb), 0);
    chk(out_cfg == expcfg(ei), "R6 config tag", 32'(out_cfg), 32'(expcfg(ei)));
    chk(nfall - base == (rb ? 32 : 16), "R3 falling edge count", 32'(nfall - base), rb ? 32 : 16);
    chk(cnv_hi - c0 == 2, "R1 convert pulse width", 32'(cnv_hi - c0), 2);
    chk(t_sck1 - t_cnv >= int'(ap_dly), "R2 aperture before first SCK", 32'(t_sck1 - t_cnv), 32'(ap_dly));
    chk(din_sr == cfgv(s), "R4 config received on DIN", 32'(din_sr), 32'(cfgv(s)));
    chk(din_hi == h0, "R4 DIN low after first word", 32'(din_hi - h0), 0);
    chk(cs_err == e0, "R7 chip select mode", 32'(cs_err - e0), 0);
    if (s % 3 == 0) begin
      hres = out_res;
      while (busy) @(negedge clk);
      repeat (3) @(negedge clk);
      start = 1;
      @(negedge clk);
      start = 0;
      chk(out_ovr, "R9 start with pending beat flags overrun", 32'(out_ovr), 1);
      chk(out_vld && out_res == hres, "R10 beat held", {15'h0, out_vld, out_res}, {15'h0, 1'b1, hres});
    end
    out_ready = 1;
    @(negedge clk);
    out_ready = 0;
    chk(!out_vld, "R10 beat taken", 32'(out_vld), 0);
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(n_cnv - n0 == 1, "R9 one convert per accepted start", 32'(n_cnv - n0), 1);
    s++;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!cnv && !sck && !din && cs_n && !out_vld, "R11 reset state",
        {27'h0, cnv, sck, din, cs_n, out_vld}, 32'h2);
    rst_n = 1;
    @(negedge clk);
    chk(!cnv && !sck && cs_n && !out_vld, "R11 idle after reset",
        {28'h0, cnv, sck, cs_n, out_vld}, 32'h2);
    for (int tm = 0; tm < 3; tm++)
      for (int mode = 0; mode < 3; mode++)
        for (int rb = 0; rb < 2; rb++)
          for (int half = 1; half < 3; half++)
            run(tm, mode, rb[0], half);
    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule